// File: doc/BRIEF.md
# Majority-Vote Dark-Bit Masking Unit

This block turns repeated readouts of an 8-bit response word into a reliable word. A host first issues a command naming an operation and a challenge address. It then streams N readouts of the response word at that address, one per `sampleValid` beat. For every bit, a counter accumulates how many of those readouts were one. When the set is complete, the block classifies each bit as majority one or zero, as unstable or not, and by a 2-bit stability grade. It then acts on the result according to the operation.

In enrolment, a nominal-condition set produces the golden word and the stability grades for the address. Further sets taken at stress conditions are compared bit by bit with that golden word. A bit that flips or wavers in any of them becomes a dark bit, and dark marks are kept until cleared. In field use the dark bits are removed first and the remaining bits are then majority-voted. Any bit that still wavers is flagged as an error for a later correction stage. Golden words, dark masks and grades live in internal register arrays with one entry per address. A clear command returns the old entry and erases it.

Top module: `mvote_mask_unit`

## Requirements
- R1: After reset `cmdReady` is 1, `resValid` is 0, and every address holds golden word 0, dark mask 0 and grade 0.
- R2: A command is taken only in a cycle where `cmdValid` and `cmdReady` are both 1. `cmdReady` stays 0 from the cycle after acceptance until the result strobe, and any command offered in that span is ignored. The result strobe appears while `cmdReady` is 1.
- R3: For the operations with codes 00, 01 and 10, a set consists of exactly N `sampleValid` beats that follow the acceptance cycle. Beats while idle and in the acceptance cycle are ignored, and gaps between beats are allowed. `resValid` is a one-cycle pulse at the second rising edge after the edge that took the N-th beat.
- R4: Let c be a bit's ones-count over the set. The majority of that bit is 1 only when 2c > N. The bit is unstable when LOW_THR < c < HIGH_THR, or when 2c = N.
- R5: `resGrade[2b+1:2b]` is the grade of bit b, coded as follows: 00 when c = 0, 11 when c = N, 10 when N/2 < c < N, and 01 otherwise.
- R6: Op 00 (nominal enrolment) overwrites the golden word with the majority word and stores the grade. It ORs the unstable bits into the mask. The result carries key = majority word, mask = updated mask, err = unstable bits and grade = this set's grade.
- R7: Op 01 (stress enrolment) flags the bits whose majority differs from the stored golden bit or which are unstable, and ORs the flags into the mask. The result carries key = stored golden word, mask = updated mask, err = flags and grade = this set's grade.
- R8: Op 10 (field) changes no stored state. The result carries key = majority AND NOT mask, mask = stored mask, err = unstable AND NOT mask and grade = this set's grade.
- R9: Op 11 (clear) takes no samples. Its result strobe comes at the second rising edge after acceptance and carries the old golden word, the old mask and the old grade, with err = 0. It then zeroes that entry.
- R10: Dark marks are sticky: a later nominal enrolment does not remove them. Each address keeps its own golden word, mask and grade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command offered |
| cmdOp | input | 2 | Operation: 00 nominal, 01 stress, 10 field, 11 clear |
| cmdAddr | input | 8 | Challenge address of the command |
| cmdReady | output | 1 | Unit idle, command can be taken |
| sampleValid | input | 1 | Readout beat |
| sampleWord | input | 8 | Readout word |
| resValid | output | 1 | Result strobe, one cycle |
| resKey | output | 8 | Key word of the result |
| resMask | output | 8 | Dark mask of the result |
| resErr | output | 8 | Error or flag bits of the result |
| resGrade | output | 16 | Two-bit grade per bit |

## Verification
Two functions can collide in a single cycle. A readout beat can arrive in the same cycle that a command is accepted, and a new command can be offered while a set is still collecting. The bench provokes the first by raising `sampleValid` with an all-ones word in the acceptance cycle. It judges the outcome from the result: the expected key, flags and grade are built only from the N beats that follow. It provokes the second by offering a clear to a different address in the middle of a set. It requires `cmdReady` to be low at that moment, and it requires a later clear of that address to return the untouched entry.

// File: rtl/mvote_mask_pkg.sv
package mvote_mask_pkg;

  typedef enum logic [1:0] {
    OP_ENROL_NOM    = 2'b00,
    OP_ENROL_STRESS = 2'b01,
    OP_FIELD        = 2'b10,
    OP_CLEAR        = 2'b11
  } mvOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  clrCnt;   // command accepted: zero the per-bit counters
    logic  accum;    // a counted readout beat
    logic  finish;   // classify, update the entry, emit the result
    mvOp_e op;       // operation of the set in progress
  } mvCtrl_s;

endpackage

// File: rtl/mvote_mask_ctrl.sv
module mvote_mask_ctrl
  import mvote_mask_pkg::*;
#(
  parameter int N      = 100,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              sampleValid,
  output logic              cmdReady,
  output mvCtrl_s           ctrl,
  output logic [ADDR_W-1:0] addrQ
);

  localparam int SCNT_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [SCNT_W-1:0] LAST_BEAT = SCNT_W'(N - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_FINISH} state_e;

  state_e            state;
  logic [SCNT_W-1:0] beatCnt;
  mvOp_e             opQ;
  logic              accept;

  assign cmdReady = (state == ST_IDLE);
  assign accept   = cmdReady && cmdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      opQ     <= OP_FIELD;
      addrQ   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            opQ     <= mvOp_e'(cmdOp);
            addrQ   <= cmdAddr;
            beatCnt <= '0;
            state   <= (mvOp_e'(cmdOp) == OP_CLEAR) ? ST_FINISH : ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (sampleValid) begin
            if (beatCnt == LAST_BEAT) state <= ST_FINISH;
            else                      beatCnt <= beatCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.clrCnt = accept;
    ctrl.accum  = (state == ST_COLLECT) && sampleValid;
    ctrl.finish = (state == ST_FINISH);
    ctrl.op     = opQ;
  end

endmodule

// File: rtl/mvote_mask_dp.sv
module mvote_mask_dp
  import mvote_mask_pkg::*;
#(
  parameter int W        = 8,
  parameter int ADDR_W   = 8,
  parameter int N        = 100,
  parameter int LOW_THR  = 0,
  parameter int HIGH_THR = N
) (
  input  logic              clk,
  input  logic              rstN,
  input  mvCtrl_s           ctrl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      sampleWord,
  output logic              resValid,
  output logic [W-1:0]      resKey,
  output logic [W-1:0]      resMask,
  output logic [W-1:0]      resErr,
  output logic [2*W-1:0]    resGrade
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(N + 1);
  localparam logic [CNT_W-1:0] N_C    = CNT_W'(N);
  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_THR);
  localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(HIGH_THR);
  localparam logic [CNT_W:0]   N_X    = (CNT_W + 1)'(N);

  // per-bit ones counters and classification
  logic [CNT_W-1:0] ones [W];
  logic [W-1:0]     passMaj;
  logic [W-1:0]     passUnst;
  logic [2*W-1:0]   passGrade;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [CNT_W:0] twice;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              ones[b] <= '0;
      else if (ctrl.clrCnt)                   ones[b] <= '0;
      else if (ctrl.accum && sampleWord[b])   ones[b] <= ones[b] + 1'b1;
    end

    assign twice       = {ones[b], 1'b0};
    assign passMaj[b]  = (twice > N_X);
    assign passUnst[b] = ((ones[b] > LOW_C) && (ones[b] < HIGH_C)) || (twice == N_X);
    assign passGrade[2*b +: 2] = (ones[b] == N_C) ? 2'b11 :
                                 (ones[b] == '0)  ? 2'b00 :
                                 (twice > N_X)    ? 2'b10 : 2'b01;
  end

  // per-address storage
  logic [W-1:0]   goldMem  [DEPTH];
  logic [W-1:0]   maskMem  [DEPTH];
  logic [2*W-1:0] gradeMem [DEPTH];

  logic [W-1:0]   goldOld, maskOld, stressFlag;
  logic [2*W-1:0] gradeOld;
  logic           wrEn;
  logic [W-1:0]   goldNext, maskNext;
  logic [2*W-1:0] gradeNext;
  logic [W-1:0]   rKey, rMask, rErr;
  logic [2*W-1:0] rGrade;

  assign goldOld    = goldMem[addr];
  assign maskOld    = maskMem[addr];
  assign gradeOld   = gradeMem[addr];
  assign stressFlag = (passMaj ^ goldOld) | passUnst;

  always_comb begin
    wrEn      = 1'b0;
    goldNext  = goldOld;
    maskNext  = maskOld;
    gradeNext = gradeOld;
    rKey      = '0;
    rMask     = maskOld;
    rErr      = '0;
    rGrade    = passGrade;
    case (ctrl.op)
      OP_ENROL_NOM: begin
        wrEn      = 1'b1;
        goldNext  = passMaj;
        gradeNext = passGrade;
        maskNext  = maskOld | passUnst;
        rKey      = passMaj;
        rMask     = maskNext;
        rErr      = passUnst;
      end
      OP_ENROL_STRESS: begin
        wrEn     = 1'b1;
        maskNext = maskOld | stressFlag;
        rKey     = goldOld;
        rMask    = maskNext;
        rErr     = stressFlag;
      end
      OP_FIELD: begin
        rKey  = passMaj & ~maskOld;
        rErr  = passUnst & ~maskOld;
      end
      default: begin
        wrEn      = 1'b1;
        goldNext  = '0;
        maskNext  = '0;
        gradeNext = '0;
        rKey      = goldOld;
        rGrade    = gradeOld;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        goldMem[i]  <= '0;
        maskMem[i]  <= '0;
        gradeMem[i] <= '0;
      end
    end else if (ctrl.finish && wrEn) begin
      goldMem[addr]  <= goldNext;
      maskMem[addr]  <= maskNext;
      gradeMem[addr] <= gradeNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resKey   <= '0;
      resMask  <= '0;
      resErr   <= '0;
      resGrade <= '0;
    end else begin
      resValid <= ctrl.finish;
      if (ctrl.finish) begin
        resKey   <= rKey;
        resMask  <= rMask;
        resErr   <= rErr;
        resGrade <= rGrade;
      end
    end
  end

endmodule

// File: rtl/mvote_mask_unit.sv
module mvote_mask_unit
  import mvote_mask_pkg::*;
#(
  parameter int W        = 8,
  parameter int ADDR_W   = 8,
  parameter int N        = 100,
  parameter int LOW_THR  = 0,
  parameter int HIGH_THR = N
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdReady,
  input  logic              sampleValid,
  input  logic [W-1:0]      sampleWord,
  output logic              resValid,
  output logic [W-1:0]      resKey,
  output logic [W-1:0]      resMask,
  output logic [W-1:0]      resErr,
  output logic [2*W-1:0]    resGrade
);

  mvCtrl_s           ctrl;
  logic [ADDR_W-1:0] addrQ;

  mvote_mask_ctrl #(.N(N), .ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdOp       (cmdOp),
    .cmdAddr     (cmdAddr),
    .sampleValid (sampleValid),
    .cmdReady    (cmdReady),
    .ctrl        (ctrl),
    .addrQ       (addrQ)
  );

  mvote_mask_dp #(
    .W(W), .ADDR_W(ADDR_W), .N(N), .LOW_THR(LOW_THR), .HIGH_THR(HIGH_THR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .addr       (addrQ),
    .sampleWord (sampleWord),
    .resValid   (resValid),
    .resKey     (resKey),
    .resMask    (resMask),
    .resErr     (resErr),
    .resGrade   (resGrade)
  );

endmodule

// File: rtl/mvote_mask_chk.sv
module mvote_mask_chk
  import mvote_mask_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         cmdValid,
  input logic [1:0]   cmdOp,
  input logic         cmdReady,
  input logic         resValid,
  input logic [W-1:0] resKey,
  input logic [W-1:0] resMask,
  input logic [W-1:0] resErr
);

  mvOp_e lastOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     lastOp <= OP_FIELD;
    else if (cmdValid && cmdReady) lastOp <= mvOp_e'(cmdOp);
  end

  // R2: busy right after a command is taken
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R2: results are only presented while idle
  a_r2_result_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> cmdReady);

  // R3: result strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R8: field key and error bits never overlap the mask
  a_r8_field_masked: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && lastOp == OP_FIELD) |-> (((resKey & resMask) == '0) && ((resErr & resMask) == '0)));

  // R7: every stress flag ends up in the reported mask
  a_r7_flags_in_mask: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && lastOp == OP_ENROL_STRESS) |-> ((resErr & ~resMask) == '0));

  // R6: nominal unstable bits end up in the reported mask
  a_r6_unstable_in_mask: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && lastOp == OP_ENROL_NOM) |-> ((resErr & ~resMask) == '0));

  // R9: a clear reports no error bits
  a_r9_clear_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && lastOp == OP_CLEAR) |-> (resErr == '0));

endmodule

bind mvote_mask_unit mvote_mask_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdReady (cmdReady),
  .resValid (resValid),
  .resKey   (resKey),
  .resMask  (resMask),
  .resErr   (resErr)
);

// File: tb/mvote_mask_unit_tb.sv
module mvote_mask_unit_tb;

  localparam int N    = 100;
  localparam int LOWT = 0;
  localparam int HIGT = N;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'b00;
  logic [7:0]  cmdAddr = '0;
  logic        cmdReady;
  logic        sampleValid = 1'b0;
  logic [7:0]  sampleWord = '0;
  logic        resValid;
  logic [7:0]  resKey, resMask, resErr;
  logic [15:0] resGrade;

  always #4 clk = ~clk;

  mvote_mask_unit #(.W(8), .ADDR_W(8), .N(N), .LOW_THR(LOWT), .HIGH_THR(HIGT)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdReady(cmdReady), .sampleValid(sampleValid), .sampleWord(sampleWord),
    .resValid(resValid), .resKey(resKey), .resMask(resMask), .resErr(resErr),
    .resGrade(resGrade)
  );

  int nChecks = 0;
  int nErrors = 0;

  typedef struct {
    logic [7:0]  key, mask, err;
    logic [15:0] grade;
    string       req;
  } exp_t;
  exp_t expQ[$];

  // reference state per address
  logic [7:0]  mGold  [256];
  logic [7:0]  mMask  [256];
  logic [15:0] mGrade [256];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic bit majOf(input int c);
    return (2 * c > N);
  endfunction
  function automatic bit unstOf(input int c);
    return ((c > LOWT) && (c < HIGT)) || (2 * c == N);
  endfunction
  function automatic logic [1:0] gradeOf(input int c);
    if (c == N)      return 2'b11;
    if (c == 0)      return 2'b00;
    if (2 * c > N)   return 2'b10;
    return 2'b01;
  endfunction

  // monitor: compare each result against the scoreboard
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(resKey   == e.key,   e.req, "key",   resKey,   e.key);
        check(resMask  == e.mask,  e.req, "mask",  resMask,  e.mask);
        check(resErr   == e.err,   e.req, "err",   resErr,   e.err);
        check(resGrade == e.grade, e.req, "grade", resGrade, e.grade);
      end
    end
  end

  // driver: one command, its readouts, and the expected result
  task automatic runSet(input logic [1:0] op, input int addr, input int c[8],
                        input bit withGaps, input bit earlyBeat,
                        input int pokeAt, input int pokeAddr, input string req);
    exp_t e;
    logic [7:0] maj, unst, flag;
    logic [15:0] grd;
    for (int b = 0; b < 8; b++) begin
      maj[b]  = majOf(c[b]);
      unst[b] = unstOf(c[b]);
      grd[2*b +: 2] = gradeOf(c[b]);
    end
    e.req = req;
    e.grade = grd;
    case (op)
      2'b00: begin
        mMask[addr] = mMask[addr] | unst;
        mGold[addr] = maj;
        mGrade[addr] = grd;
        e.key = maj; e.mask = mMask[addr]; e.err = unst;
      end
      2'b01: begin
        flag = (maj ^ mGold[addr]) | unst;
        mMask[addr] = mMask[addr] | flag;
        e.key = mGold[addr]; e.mask = mMask[addr]; e.err = flag;
      end
      2'b10: begin
        e.key = maj & ~mMask[addr]; e.mask = mMask[addr]; e.err = unst & ~mMask[addr];
      end
      default: begin
        e.key = mGold[addr]; e.mask = mMask[addr]; e.err = '0; e.grade = mGrade[addr];
        mGold[addr] = '0; mMask[addr] = '0; mGrade[addr] = '0;
      end
    endcase
    expQ.push_back(e);

    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = 8'(addr);
    if (earlyBeat) begin
      sampleValid = 1'b1; sampleWord = 8'hFF;   // R3: must not be counted
    end
    @(negedge clk);
    cmdValid = 1'b0; sampleValid = 1'b0;
    if (op != 2'b11) begin
      for (int i = 0; i < N; i++) begin
        if (withGaps && (i % 7 == 3)) begin
          sampleValid = 1'b0;
          @(negedge clk);
        end
        sampleValid = 1'b1;
        for (int b = 0; b < 8; b++) sampleWord[b] = (i < c[b]);
        if (i == pokeAt) begin
          check(cmdReady == 1'b0, "R2", "ready while collecting", cmdReady, 0);
          cmdValid = 1'b1; cmdOp = 2'b11; cmdAddr = 8'(pokeAddr);
        end
        @(negedge clk);
        cmdValid = 1'b0;
      end
      sampleValid = 1'b0;
      check(resValid == 1'b0, "R3", "strobe one cycle after last beat", resValid, 0);
    end else begin
      check(resValid == 1'b0, "R9", "strobe one cycle after accept", resValid, 0);
    end
    @(negedge clk);
    check(resValid == 1'b1, (op == 2'b11) ? "R9" : "R3", "strobe latency", resValid, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      mGold[a] = '0; mMask[a] = '0; mGrade[a] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cmdReady == 1'b1, "R1", "cmdReady after reset", cmdReady, 1);
    check(resValid == 1'b0, "R1", "resValid after reset", resValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R3: beats while idle are ignored
    sampleValid = 1'b1; sampleWord = 8'hFF;
    repeat (3) @(negedge clk);
    sampleValid = 1'b0;
    check(resValid == 1'b0, "R3", "no result from idle beats", resValid, 0);

    // R1 R4 R5 R8: field pass on a fresh entry, mixed counts incl. exact half
    runSet(2'b10, 5, '{0, 100, 50, 49, 51, 1, 99, 100}, 1'b0, 1'b0, -1, 0, "R8");
    // R6: nominal enrolment, one unstable bit
    runSet(2'b00, 5, '{0, 100, 100, 0, 100, 0, 97, 100}, 1'b0, 1'b0, -1, 0, "R6");
    // R7: stress pass with one flipped bit
    runSet(2'b01, 5, '{0, 100, 0, 0, 100, 0, 100, 100}, 1'b0, 1'b0, -1, 0, "R7");
    // R3 R7: stress pass with gaps and a beat in the acceptance cycle
    runSet(2'b01, 5, '{30, 100, 100, 0, 100, 0, 100, 100}, 1'b1, 1'b1, -1, 0, "R7");
    // R8: field pass masks dark bits, flags remaining unstable bit
    runSet(2'b10, 5, '{0, 100, 60, 0, 100, 50, 40, 100}, 1'b0, 1'b0, -1, 0, "R8");
    // R10: re-enrol nominal, all stable: marks remain
    runSet(2'b00, 5, '{0, 100, 100, 0, 100, 0, 100, 100}, 1'b0, 1'b0, -1, 0, "R10");
    // R10: another address is independent
    runSet(2'b00, 9, '{100, 0, 75, 25, 100, 0, 100, 0}, 1'b0, 1'b0, -1, 0, "R10");
    // R2: field pass on 9 with a clear of 5 offered mid-set
    runSet(2'b10, 9, '{100, 0, 100, 0, 3, 0, 100, 0}, 1'b0, 1'b0, 40, 5, "R2");
    // R9: clear returns the intact old entry of 5
    runSet(2'b11, 5, '{0, 0, 0, 0, 0, 0, 0, 0}, 1'b0, 1'b0, -1, 0, "R9");
    // R9: after clear, field pass sees no mask
    runSet(2'b10, 5, '{0, 100, 60, 0, 100, 50, 40, 100}, 1'b0, 1'b0, -1, 0, "R9");
    // R9: second clear returns zero entry
    runSet(2'b11, 5, '{0, 0, 0, 0, 0, 0, 0, 0}, 1'b0, 1'b0, -1, 0, "R9");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R3", "results outstanding", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule